// File: doc/BRIEF.md
# Bus Access Recovery Guard

This block sits between a host's read and write strobes and a peripheral's register logic. All of it runs on the peripheral clock. The host strobes have no phase relationship to that clock. Each strobe therefore passes through a synchronizer chain before it is allowed to act, which gives metastable samples time to resolve. A synchronized rising edge becomes a one-cycle internal read or write pulse. The host address and write data are captured on the same clock edge as that pulse.

Each internal pulse opens a recovery window, and no other access may start inside it. This applies to every access. Two reads of the same receive queue in a row wait for it, and so do accesses that alternate between channel addresses. The window length is set by a mode input.

A strobe that arrives inside the window is handled by one of two policies:
- **Stall policy:** the access is held pending and the host sees a wait signal. The access is carried out as soon as the window closes.
- **Flag policy:** the access is dropped and a one-cycle violation flag is raised.

Top module: `bus_recovery_guard`

## Requirements
- R1: Reset is synchronous and active high. It clears all pulses, the wait signal, the violation flag, any pending access and the recovery counter. A strobe raised in the first cycle after reset is accepted with the idle latency of R2, even if reset arrived while a recovery window was running.
- R2: Timing of an accepted access:
  - A strobe first sampled high at clock edge k produces its internal pulse in the cycle after edge k+2, when the block is idle.
  - The pulse lasts exactly one cycle, however long the strobe stays high.
  - A new pulse needs a new rising edge of the strobe.
- R3: The strobe sets the pulse type: `host_rd` produces `int_rd` and `host_wr` produces `int_wr`. `int_addr` and `int_wdata` hold the host address and data sampled on the edge that raises the pulse.
- R4: After every internal pulse, no further pulse occurs for the next G cycles. This holds for any mix of reads, writes and addresses. G is set by R6 and R7.
- R5: Stall policy (`stall_en`=1):
  - A strobe edge that is evaluated while the window is open makes `host_wait` high from the next edge onward.
  - The access is performed on the first edge after the window closes, which is the (G+1)th edge after the previous pulse.
  - `host_wait` falls on that same edge.
- R6: `rec_mode` encoding: 2'b00 gives G=3, 2'b10 gives G=4, and 2'b11 also gives G=4.
- R7: `rec_mode`=2'b01 gives a 3.5-cycle window. Internal pulses keep G=4 spacing. A stalled host sees `host_wait` fall on the falling clock edge half a cycle before the pending pulse.
- R8: Flag policy (`stall_en`=0):
  - A strobe edge evaluated during the window produces no internal pulse and never raises `host_wait`.
  - It raises `viol` for one cycle, in the cycle its pulse would have started at idle.
  - It does not restart the window.
- R9: Read and write edges evaluated in the same idle cycle: the read is performed first. The write is then treated as arriving during the read's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Asynchronous host read strobe, active high |
| host_wr | input | 1 | Asynchronous host write strobe, active high |
| host_addr | input | AW | Host address, held stable while an access is outstanding |
| host_wdata | input | DW | Host write data |
| rec_mode | input | 2 | Recovery window select (R6, R7) |
| stall_en | input | 1 | 1: stall policy, 0: flag policy |
| int_rd | output | 1 | One-cycle internal read pulse |
| int_wr | output | 1 | One-cycle internal write pulse |
| int_addr | output | AW | Address captured with the pulse |
| int_wdata | output | DW | Write data captured with the pulse |
| host_wait | output | 1 | Stall indication to the host |
| viol | output | 1 | One-cycle violation flag |

## Verification
An idle access has its pulse due exactly three cycles after the first sampling edge. A stalled access is due G+1 cycles after the pulse before it, and a violation flag is due at the idle pulse position. The driver computes each due cycle from these rules when it raises a strobe and queues it together with the expected type, address and data. The monitor samples two time units after every rising edge and compares each pulse or flag against the head of the queue, so a pulse that is early, late or one cycle too long shows up as a mismatch. The wait signal is checked one cycle before and on the release edge, and in the half-cycle mode also just after the falling edge in between.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int GUARD_W = 3;

    typedef enum logic [1:0] {
        GUARD_3  = 2'b00,
        GUARD_3H = 2'b01,
        GUARD_4  = 2'b10,
        GUARD_4B = 2'b11
    } guard_mode_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_pair_t;

    // Full cycles of recovery loaded after each internal pulse.
    function automatic logic [GUARD_W-1:0] guard_cycles(input guard_mode_e m);
        return (m == GUARD_3) ? GUARD_W'(3) : GUARD_W'(4);
    endfunction

    // Modes whose host-visible release happens on the falling edge.
    function automatic logic early_release(input guard_mode_e m);
        return m == GUARD_3H;
    endfunction

    // Pick the access to perform: pending read, pending write, new read, new write.
    function automatic acc_pair_t pick_access(input acc_pair_t pend,
                                              input acc_pair_t fresh,
                                              input logic      idle);
        acc_pair_t sel;
        sel.rd = idle & (pend.rd | (~pend.wr & fresh.rd));
        sel.wr = idle & ~sel.rd & (pend.wr | fresh.wr);
        return sel;
    endfunction

endpackage

// File: rtl/brg_strobe_sync.sv
module brg_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic rise
);
    localparam int CHAIN_LEN = STAGES + 1;

    // chain[STAGES-1] is the settled sample, chain[STAGES] its previous value.
    logic [CHAIN_LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_LEN-2:0], strobe_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/brg_guard_timer.sv
module brg_guard_timer
    import brg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  guard_mode_e mode,
    input  logic        pend_any,
    output logic        busy,
    output logic        early
);
    logic [GUARD_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= guard_cycles(mode);
        end else if (remain != '0) begin
            remain <= remain - GUARD_W'(1);
        end
    end

    assign busy = (remain != '0);

    // Falling-edge stage: lets the host see the release half a cycle
    // before the rising edge that performs the pending access.
    always_ff @(negedge clk) begin
        if (rst) begin
            early <= 1'b0;
        end else begin
            early <= early_release(mode) & pend_any & ~busy;
        end
    end

endmodule

// File: rtl/brg_access_ctrl.sv
module brg_access_ctrl
    import brg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_pair_t     fresh,
    input  logic          busy,
    input  logic          stall_en,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          int_rd,
    output logic          int_wr,
    output logic [AW-1:0] int_addr,
    output logic [DW-1:0] int_wdata,
    output logic          pend_any,
    output logic          viol,
    output logic          fire
);
    acc_pair_t pend_q;
    acc_pair_t sel;
    acc_pair_t leftover;
    acc_pair_t pend_d;

    always_comb begin
        sel         = pick_access(pend_q, fresh, ~busy);
        leftover.rd = fresh.rd & ~(sel.rd & ~pend_q.rd);
        leftover.wr = fresh.wr & ~(sel.wr & ~pend_q.wr);
        pend_d.rd   = (pend_q.rd & ~sel.rd) | (stall_en & leftover.rd);
        pend_d.wr   = (pend_q.wr & ~sel.wr) | (stall_en & leftover.wr);
    end

    assign fire     = sel.rd | sel.wr;
    assign pend_any = pend_q.rd | pend_q.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            int_rd    <= 1'b0;
            int_wr    <= 1'b0;
            viol      <= 1'b0;
            int_addr  <= '0;
            int_wdata <= '0;
        end else begin
            pend_q <= pend_d;
            int_rd <= sel.rd;
            int_wr <= sel.wr;
            viol   <= ~stall_en & (leftover.rd | leftover.wr);
            if (fire) begin
                int_addr  <= addr_in;
                int_wdata <= data_in;
            end
        end
    end

endmodule

// File: rtl/bus_recovery_guard.sv
module bus_recovery_guard
    import brg_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [1:0]    rec_mode,
    input  logic          stall_en,
    output logic          int_rd,
    output logic          int_wr,
    output logic [AW-1:0] int_addr,
    output logic [DW-1:0] int_wdata,
    output logic          host_wait,
    output logic          viol
);
    localparam int N_STROBES = 2;

    logic [N_STROBES-1:0] strobe_raw;
    logic [N_STROBES-1:0] strobe_rise;
    acc_pair_t            fresh;
    logic                 busy;
    logic                 early;
    logic                 pend_any;
    logic                 fire;
    guard_mode_e          mode;

    assign strobe_raw = {host_rd, host_wr};
    assign mode       = guard_mode_e'(rec_mode);

    for (genvar s = 0; s < N_STROBES; s++) begin : g_sync
        brg_strobe_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk       (clk),
            .rst       (rst),
            .strobe_in (strobe_raw[s]),
            .rise      (strobe_rise[s])
        );
    end

    assign fresh.rd = strobe_rise[1];
    assign fresh.wr = strobe_rise[0];

    brg_guard_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .mode     (mode),
        .pend_any (pend_any),
        .busy     (busy),
        .early    (early)
    );

    brg_access_ctrl #(
        .AW (AW),
        .DW (DW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fresh     (fresh),
        .busy      (busy),
        .stall_en  (stall_en),
        .addr_in   (host_addr),
        .data_in   (host_wdata),
        .int_rd    (int_rd),
        .int_wr    (int_wr),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .pend_any  (pend_any),
        .viol      (viol),
        .fire      (fire)
    );

    assign host_wait = pend_any & ~early;

endmodule

// File: rtl/bus_recovery_guard_chk.sv
module bus_recovery_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       int_rd,
    input logic       int_wr,
    input logic       host_wait,
    input logic       viol,
    input logic       stall_en,
    input logic [1:0] rec_mode
);
    logic acc;
    assign acc = int_rd | int_wr;

    assert_rd_single_R2: assert property (@(posedge clk) disable iff (rst)
        int_rd |=> !int_rd);

    assert_wr_single_R2: assert property (@(posedge clk) disable iff (rst)
        int_wr |=> !int_wr);

    assert_guard_gap_R4: assert property (@(posedge clk) disable iff (rst)
        acc |-> (!$past(acc, 1) || $past(rst, 1))
             && (!$past(acc, 2) || $past(rst, 1) || $past(rst, 2))
             && (!$past(acc, 3) || $past(rst, 1) || $past(rst, 2) || $past(rst, 3)));

    assert_guard_four_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && rec_mode != 2'b00) |->
            (!$past(acc, 4) || $past(rst, 1) || $past(rst, 2) || $past(rst, 3)
             || $past(rst, 4)));

    assert_wait_stall_only_R5: assert property (@(posedge clk) disable iff (rst)
        host_wait |-> stall_en);

    assert_viol_flag_only_R8: assert property (@(posedge clk) disable iff (rst)
        viol |-> !$past(stall_en));

    assert_no_dual_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !(int_rd && int_wr));

endmodule

bind bus_recovery_guard bus_recovery_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .int_rd    (int_rd),
    .int_wr    (int_wr),
    .host_wait (host_wait),
    .viol      (viol),
    .stall_en  (stall_en),
    .rec_mode  (rec_mode)
);

// File: tb/test_bus_recovery_guard.sv
module test_bus_recovery_guard;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [1:0]    rec_mode = 2'b00;
    logic          stall_en = 1'b1;
    logic          int_rd, int_wr, host_wait, viol;
    logic [AW-1:0] int_addr;
    logic [DW-1:0] int_wdata;

    bus_recovery_guard #(.AW(AW), .DW(DW)) i_bus_recovery_guard (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .rec_mode(rec_mode),
        .stall_en(stall_en), .int_rd(int_rd), .int_wr(int_wr),
        .int_addr(int_addr), .int_wdata(int_wdata), .host_wait(host_wait),
        .viol(viol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            kind;   // 1 read, 2 write
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            at;
    } exp_t;

    exp_t acc_q[$];
    int   viol_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   last_fire = -100;
    int   cur_len = 3;
    bit   done = 0;

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a pulse or a flag appears.
    always begin : monitor
        int   k;
        int   v;
        exp_t e;
        @(posedge clk);
        #2;
        if (!rst) begin
            if (int_rd || int_wr) begin
                k = int_rd ? 1 : 2;
                if (acc_q.size() == 0) begin
                    check("R4 unexpected internal pulse", 1'b0, cyc, -1);
                end else begin
                    e = acc_q.pop_front();
                    check("R2 pulse cycle", cyc == e.at, cyc, e.at);
                    check("R3 pulse kind", k == e.kind, k, e.kind);
                    check("R3 captured address", int_addr == e.a, int'(int_addr), int'(e.a));
                    if (k == 2)
                        check("R3 captured write data", int_wdata == e.d,
                              int'(int_wdata), int'(e.d));
                end
            end
            if (viol) begin
                if (viol_q.size() == 0) begin
                    check("R8 unexpected violation", 1'b0, cyc, -1);
                end else begin
                    v = viol_q.pop_front();
                    check("R8 violation cycle", cyc == v, cyc, v);
                end
            end
        end
    end

    task automatic push_acc(input int kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int at);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.at = at;
        acc_q.push_back(e);
        last_fire = at;
    endtask

    // Driver: caller is at a falling edge; returns at a falling edge.
    // kind 1 read, 2 write, 3 both strobes together.
    task automatic access(input int kind, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int hold);
        int t;
        int f;
        while (cyc < last_fire) @(negedge clk);   // host honours wait
        t = cyc;
        host_addr  = a;
        host_wdata = d;
        host_rd    = (kind != 2);
        host_wr    = (kind != 1);
        f = (t + 3 > last_fire + cur_len + 1) ? t + 3 : last_fire + cur_len + 1;
        if (stall_en || f == t + 3) begin
            if (kind == 3) begin
                push_acc(1, a, d, f);
                if (stall_en) push_acc(2, a, d, f + cur_len + 1);
                else viol_q.push_back(t + 3);
            end else begin
                push_acc(kind, a, d, f);
            end
        end else begin
            viol_q.push_back(t + 3);
        end
        repeat (hold) @(negedge clk);
        host_rd = 1'b0;
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic at_cycle_pos(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
        #1;
    endtask

    task automatic set_mode(input logic [1:0] m, input logic s);
        repeat (8) @(negedge clk);
        rec_mode = m;
        stall_en = s;
        cur_len  = (m == 2'b00) ? 3 : 4;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int ta;
        rst = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 reset int_rd", int_rd == 1'b0, int_rd, 0);
        check("R1 reset int_wr", int_wr == 1'b0, int_wr, 0);
        check("R1 reset host_wait", host_wait == 1'b0, host_wait, 0);
        check("R1 reset viol", viol == 1'b0, viol, 0);
        @(negedge clk);

        // R2/R3: isolated read, then a long write giving one pulse.
        access(1, 8'h11, 8'h00, 2);
        repeat (6) @(negedge clk);
        access(2, 8'h22, 8'hA5, 9);
        repeat (6) @(negedge clk);

        // R5: back-to-back reads of one queue address, 3-cycle window.
        ta = cyc;
        access(1, 8'h30, 8'h00, 2);
        access(1, 8'h30, 8'h00, 2);
        #2;
        check("R5 wait high before release", host_wait == 1'b1, host_wait, 1);
        at_cycle_pos(ta + 7);
        check("R5 wait low on release edge", host_wait == 1'b0, host_wait, 0);
        @(negedge clk);

        // R4: alternating channels, write/read/write.
        access(2, 8'h40, 8'h5A, 2);
        access(1, 8'h80, 8'h00, 2);
        access(2, 8'h41, 8'hC3, 2);

        // R6: 4-cycle window.
        set_mode(2'b10, 1'b1);
        ta = cyc;
        access(1, 8'h50, 8'h00, 2);
        access(2, 8'h51, 8'h77, 2);
        at_cycle_pos(ta + 7);
        @(negedge clk);
        #2;
        check("R6 wait still high in 4th window cycle", host_wait == 1'b1, host_wait, 1);
        @(negedge clk);
        set_mode(2'b11, 1'b1);
        access(1, 8'h52, 8'h00, 2);
        access(1, 8'h53, 8'h00, 2);

        // R7: 3.5-cycle window.
        set_mode(2'b01, 1'b1);
        ta = cyc;
        access(1, 8'h60, 8'h00, 2);
        access(1, 8'h61, 8'h00, 2);
        at_cycle_pos(ta + 7);
        check("R7 wait high before falling edge", host_wait == 1'b1, host_wait, 1);
        @(negedge clk);
        #2;
        check("R7 wait released on falling edge", host_wait == 1'b0, host_wait, 0);
        @(negedge clk);

        // R8: flag policy, dropped access, window not restarted.
        set_mode(2'b00, 1'b0);
        access(1, 8'h70, 8'h00, 2);
        access(2, 8'h71, 8'h99, 2);
        #2;
        check("R8 wait never raised in flag policy", host_wait == 1'b0, host_wait, 0);
        @(negedge clk);
        access(1, 8'h72, 8'h00, 2);

        // R9: both strobes together, stall then flag policy.
        set_mode(2'b00, 1'b1);
        access(3, 8'h90, 8'h3C, 2);
        set_mode(2'b00, 1'b0);
        access(3, 8'h91, 8'h4D, 2);

        // R1: reset inside a running 4-cycle window.
        set_mode(2'b10, 1'b1);
        access(1, 8'hA0, 8'h00, 2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        last_fire = -100;
        access(1, 8'hA1, 8'h00, 2);

        repeat (12) @(negedge clk);
        check("R4 all expected pulses and flags observed",
              acc_q.size() == 0 && viol_q.size() == 0,
              acc_q.size() + viol_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule